// File: doc/BRIEF.md
# Converter Conversion Sequencer and Control Register

This block is the digital side of an analog-to-digital converter. Software reaches it through a small 8-bit register interface with two addresses: a control word and a channel/mode word. From these it sequences conversions. It gates the converter clock through a programmable prescaler, issues a one-cycle start pulse and counts converter clock ticks until a conversion ends. At the end it captures the converter's result word and raises an interrupt flag.

Conversions are started in one of three ways. Software can write the start bit. In auto-trigger mode a rising edge on an external trigger input starts one. In free-running mode each conversion starts the next. The first conversion after the converter is enabled is a longer initialization conversion. Channel selection written during a conversion is held back until that conversion ends. Turning off the enable lets the running conversion finish. The tick counter itself stands in for the converter's done strobe.

Top module: `adc_conv_ctl`

## Requirements
- R1: After reset, both registers read 0x00, `irq` is 0 and `conv_chan` is 0.
- R2: Control word (address 0) bits: [7] enable, [6] start/busy, [5] auto-trigger enable, [4] interrupt flag, [3] interrupt enable, [2:0] prescaler code. Codes 0..7 divide the system clock by 2,2,4,8,16,32,64,128. A conversion lasts NORM_LEN ticks, so the flag rises exactly NORM_LEN*div clock edges after the starting write edge.
- R3: Writing bit 6 as 1 together with bit 7 as 1 while idle starts a conversion. Bit 6 then reads 1 until the conversion ends, and hardware clears it then. Writing bit 6 as 0 during a conversion has no effect. A start written with bit 7 at 0 is ignored.
- R4: The first conversion after enabling lasts FIRST_LEN ticks and drives `conv_first` high. Once the converter has been idle with enable cleared, the next conversion is again a first one.
- R5: Clearing enable during a conversion does not abort it. The conversion completes at its normal time and sets the flag.
- R6: On the clock edge that ends a conversion, `result_out` takes the value of `result_in` and the flag sets.
- R7: The flag is cleared by a pulse on `irq_ack` or by writing 1 to bit 4. Writing 0 to bit 4 leaves it unchanged. A conversion end in the same cycle wins over a clear.
- R8: `irq` is high exactly when both the flag and the interrupt enable (bit 3) are set.
- R9: With auto-trigger on and the free-run bit (address 1, bit 7) at 0, a rising edge on `ext_trig` starts a conversion while enabled and idle. With auto-trigger off, `ext_trig` is ignored.
- R10: With auto-trigger on and free-run set, a software start begins a chain in which each conversion end starts the next. Clearing auto-trigger lets the current conversion finish and stops the chain.
- R11: Address 1 bits [CH_W-1:0] select the channel. When written while idle, the value reaches `conv_chan` on the next edge. When written during a conversion, it is held pending (and reads back) and is applied when that conversion ends.
- R12: `conv_start` is a one-cycle pulse, issued once for each conversion started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = channel/mode word |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq_ack | input | 1 | Interrupt serviced; clears the flag |
| ext_trig | input | 1 | External trigger event (asynchronous) |
| result_in | input | DATA_W | Result word from the converter core |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_first | output | 1 | Current conversion is the initialization one |
| conv_clk_en | output | 1 | Divided converter clock enable tick |
| conv_chan | output | CH_W | Channel applied to the converter |
| result_out | output | DATA_W | Captured conversion result |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with FIRST_LEN=5, NORM_LEN=3 and CH_W=3. Conversions are therefore short enough to sweep all eight prescaler codes, and to compare each conversion length with NORM_LEN times the computed divisor to the exact edge. The short lengths also leave room for the mid-conversion cases: enable cleared, start written as zero, and channel changed. They make it cheap to chain several free-running conversions and to re-enter the initialization length after a disable.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;

   localparam int PS_W = 3;

   typedef struct packed {
      logic           en;
      logic           busy;
      logic           auto_trig;
      logic           flag;
      logic           int_en;
      logic [PS_W-1:0] ps;
   } ctrl_view_t;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PS_W-1:0] ps,
   output logic            tick
);
   localparam int CW = (1 << PS_W) - 1;

   logic [CW-1:0] cnt;
   logic [CW:0]   div;

   always_comb begin
      if (ps == '0) div = (CW+1)'(2);
      else          div = (CW+1)'(1) << ps;
   end

   assign tick = run && ({1'b0, cnt} == div - (CW+1)'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run || tick) cnt <= '0;
      else                        cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
   parameter int SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic rise
);
   logic smp;
   logic smp_q;

   generate
      if (SYNC == 0) begin : g_direct
         assign smp = trig_in;
      end else begin : g_sync
         logic [SYNC-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC-2:0], trig_in};
         end
         assign smp = chain[SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) smp_q <= 1'b0;
      else        smp_q <= smp;
   end

   assign rise = smp & ~smp_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
   parameter int FIRST_LEN = 25,
   parameter int NORM_LEN  = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic first_req,
   input  logic tick,
   output logic busy,
   output logic done,
   output logic first
);
   localparam int TW = $clog2(FIRST_LEN + 1);

   logic [TW-1:0] tcnt;
   logic [TW-1:0] last;

   assign last = first ? TW'(FIRST_LEN - 1) : TW'(NORM_LEN - 1);
   assign done = busy && tick && (tcnt == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         first <= 1'b0;
         tcnt  <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         first <= first_req;
         tcnt  <= '0;
      end else if (done) begin
         busy  <= 1'b0;
         first <= 1'b0;
      end else if (busy && tick) begin
         tcnt  <= tcnt + TW'(1);
      end
   end
endmodule

// File: rtl/adc_conv_ctl.sv
module adc_conv_ctl
   import adc_conv_pkg::*;
#(
   parameter int CH_W      = 4,
   parameter int DATA_W    = 10,
   parameter int FIRST_LEN = 25,
   parameter int NORM_LEN  = 13,
   parameter int TRIG_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              irq_ack,
   input  logic              ext_trig,
   input  logic [DATA_W-1:0] result_in,
   output logic              conv_start,
   output logic              conv_first,
   output logic              conv_clk_en,
   output logic [CH_W-1:0]   conv_chan,
   output logic [DATA_W-1:0] result_out,
   output logic              irq
);
   generate
      if (CH_W < 1 || CH_W > 6) begin : g_bad_ch
         $error("adc_conv_ctl: CH_W must be 1..6");
      end
      if (NORM_LEN < 1 || FIRST_LEN < NORM_LEN) begin : g_bad_len
         $error("adc_conv_ctl: need 1 <= NORM_LEN <= FIRST_LEN");
      end
      if (TRIG_SYNC == 1 || TRIG_SYNC < 0) begin : g_bad_sync
         $error("adc_conv_ctl: TRIG_SYNC must be 0 or >= 2");
      end
   endgenerate

   logic            en_r, ate_r, ie_r, flag_r, fr_r;
   logic [PS_W-1:0] ps_r;
   logic [CH_W-1:0] ch_r, ch_p;
   logic            pend_v;
   logic            init_done;
   logic            done_q;
   logic            busy, done, tick, trig_rise;
   logic            wr_ctl, wr_ch;
   logic            sw_start, trig_start, fr_start, start_now;
   ctrl_view_t      view;

   assign wr_ctl = reg_wr && !reg_addr;
   assign wr_ch  = reg_wr &&  reg_addr;

   assign sw_start   = wr_ctl && reg_wdata[6] && reg_wdata[7];
   assign trig_start = en_r && ate_r && !fr_r && trig_rise;
   assign fr_start   = en_r && ate_r && fr_r && done_q;
   assign start_now  = !busy && (sw_start || trig_start || fr_start);

   adc_clk_div #(.PS_W(PS_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .ps(ps_r), .tick(tick)
   );

   adc_trig_edge #(.SYNC(TRIG_SYNC)) u_trig (
      .clk(clk), .rst_n(rst_n), .trig_in(ext_trig), .rise(trig_rise)
   );

   adc_conv_seq #(.FIRST_LEN(FIRST_LEN), .NORM_LEN(NORM_LEN)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start_now), .first_req(!init_done),
      .tick(tick), .busy(busy), .done(done), .first(conv_first)
   );

   // control word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_r   <= 1'b0;
         ate_r  <= 1'b0;
         ie_r   <= 1'b0;
         ps_r   <= '0;
         flag_r <= 1'b0;
      end else begin
         if (wr_ctl) begin
            en_r  <= reg_wdata[7];
            ate_r <= reg_wdata[5];
            ie_r  <= reg_wdata[3];
            ps_r  <= reg_wdata[PS_W-1:0];
         end
         if (done)
            flag_r <= 1'b1;
         else if (irq_ack || (wr_ctl && reg_wdata[4]))
            flag_r <= 1'b0;
      end
   end

   // sequencing state, result capture, start pulse
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_done  <= 1'b0;
         done_q     <= 1'b0;
         conv_start <= 1'b0;
         result_out <= '0;
      end else begin
         done_q     <= done;
         conv_start <= start_now;
         if (done) begin
            init_done  <= 1'b1;
            result_out <= result_in;
         end else if (!en_r && !busy) begin
            init_done  <= 1'b0;
         end
      end
   end

   // channel / mode word with deferred channel update
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fr_r   <= 1'b0;
         ch_r   <= '0;
         ch_p   <= '0;
         pend_v <= 1'b0;
      end else begin
         if (wr_ch) begin
            fr_r <= reg_wdata[7];
            if (!busy || done) begin
               ch_r   <= reg_wdata[CH_W-1:0];
               pend_v <= 1'b0;
            end else begin
               ch_p   <= reg_wdata[CH_W-1:0];
               pend_v <= 1'b1;
            end
         end else if (done && pend_v) begin
            ch_r   <= ch_p;
            pend_v <= 1'b0;
         end
      end
   end

   assign conv_chan   = ch_r;
   assign conv_clk_en = tick;
   assign irq         = flag_r && ie_r;

   always_comb begin
      view.en        = en_r;
      view.busy      = busy;
      view.auto_trig = ate_r;
      view.flag      = flag_r;
      view.int_en    = ie_r;
      view.ps        = ps_r;
      if (reg_addr) begin
         reg_rdata    = 8'(pend_v ? ch_p : ch_r);
         reg_rdata[7] = fr_r;
      end else begin
         reg_rdata    = view;
      end
   end
endmodule

// File: rtl/adc_conv_ctl_chk.sv
module adc_conv_ctl_chk #(
   parameter int CH_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            conv_start,
   input logic [CH_W-1:0] conv_chan,
   input logic            irq,
   input logic            flag,
   input logic            busy,
   input logic            en
);
   p_start_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   p_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   p_start_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> (en || $past(en)));

   p_flag_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $fell(busy));

   p_chan_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(conv_chan));

   p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);
endmodule

bind adc_conv_ctl adc_conv_ctl_chk #(.CH_W(CH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
   .irq(irq), .flag(flag_r), .busy(busy), .en(en_r)
);

// File: tb/sim_adc_conv_ctl.sv
module sim_adc_conv_ctl;
   localparam int CH_W = 3;
   localparam int DW   = 10;
   localparam int FL   = 5;
   localparam int NL   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_addr = 1'b0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          irq_ack = 1'b0;
   logic          ext_trig = 1'b0;
   logic [DW-1:0] result_in = '0;
   logic          conv_start, conv_first, conv_clk_en, irq;
   logic [CH_W-1:0] conv_chan;
   logic [DW-1:0] result_out;

   int checks = 0;
   int fails  = 0;
   int starts = 0;
   int n;
   bit done_run = 0;

   always #5 clk = ~clk;

   adc_conv_ctl #(.CH_W(CH_W), .DATA_W(DW), .FIRST_LEN(FL), .NORM_LEN(NL),
                  .TRIG_SYNC(2)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
      .ext_trig(ext_trig), .result_in(result_in), .conv_start(conv_start),
      .conv_first(conv_first), .conv_clk_en(conv_clk_en), .conv_chan(conv_chan),
      .result_out(result_out), .irq(irq)
   );

   always @(negedge clk) if (rst_n && conv_start) starts++;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input bit a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_addr = 1'b0;
   endtask

   task automatic wait_flag(input int n0, output int cnt);
      cnt = n0;
      while (reg_rdata[4] !== 1'b1 && cnt < 2000) begin
         @(posedge clk); #1;
         cnt++;
      end
   endtask

   function automatic int divof(input int c);
      return (c == 0) ? 2 : (1 << c);
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done_run) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 ctrl", reg_rdata, 0);
      reg_addr = 1'b1; #1;
      check("R1 chan reg", reg_rdata, 0);
      reg_addr = 1'b0; #1;
      check("R1 irq", irq, 0);
      check("R1 conv_chan", conv_chan, 0);

      // R3 start without enable is ignored
      wr(0, 8'h40);
      repeat (4) step();
      check("R3 start while disabled", reg_rdata[6], 0);
      check("R3 no pulse while disabled", starts, 0);

      // R4/R2 first conversion, ps=0, ie on
      result_in = 10'h2A5;
      wr(0, 8'hC8);
      check("R3 busy reads 1", reg_rdata[6], 1);
      check("R4 conv_first", conv_first, 1);
      wait_flag(0, n);
      check("R4 first length", n, FL * 2);
      check("R3 busy cleared at end", reg_rdata[6], 0);
      check("R6 result captured", result_out, 10'h2A5);
      check("R8 irq with ie", irq, 1);
      @(negedge clk) irq_ack = 1'b1;
      @(posedge clk); #1 irq_ack = 1'b0;
      check("R7 ack clears flag", reg_rdata[4], 0);
      check("R8 irq drops", irq, 0);

      // R2 prescaler sweep, normal length
      for (int p = 0; p < 8; p++) begin
         result_in = DW'(p * 37 + 1);
         wr(0, 8'hC0 | 8'(p));
         check("R4 later not first", conv_first, 0);
         wait_flag(0, n);
         check($sformatf("R2 length ps=%0d", p), n, NL * divof(p));
         check("R6 result", result_out, p * 37 + 1);
         check("R8 no irq without ie", irq, 0);
         wr(0, 8'h80 | 8'(p));
         check("R7 write 0 keeps flag", reg_rdata[4], 1);
         wr(0, 8'h90);
         check("R7 write 1 clears flag", reg_rdata[4], 0);
      end

      // R3 write zero to start during conversion
      wr(0, 8'hC0);
      step();
      wr(0, 8'h80);
      check("R3 zero write keeps busy", reg_rdata[6], 1);
      wait_flag(2, n);
      check("R3 length unchanged", n, NL * 2);
      wr(0, 8'h90);

      // R5 disable mid conversion
      wr(0, 8'hC0);
      step();
      wr(0, 8'h00);
      check("R5 still busy after disable", reg_rdata[6], 1);
      wait_flag(2, n);
      check("R5 completes on time", n, NL * 2);
      check("R5 idle after", reg_rdata[6], 0);
      wr(0, 8'h10);
      step();
      // R4 re-enable gives initialization length
      wr(0, 8'hC0);
      check("R4 conv_first again", conv_first, 1);
      wait_flag(0, n);
      check("R4 first length again", n, FL * 2);
      wr(0, 8'h90);

      // R11 channel handling
      wr(1, 8'h05);
      check("R11 idle write immediate", conv_chan, 5);
      wr(0, 8'hC0);
      wr(1, 8'h02);
      check("R11 held during conversion", conv_chan, 5);
      reg_addr = 1'b1; #1;
      check("R11 pending reads back", reg_rdata, 2);
      reg_addr = 1'b0; #1;
      wait_flag(0, n);
      check("R11 applied at end", conv_chan, 2);
      wr(0, 8'h90);

      // R9 external trigger
      ext_trig = 1'b1; repeat (2) step(); ext_trig = 1'b0;
      repeat (6) step();
      check("R9 trigger ignored w/o auto", reg_rdata[6], 0);
      wr(0, 8'hA0);
      ext_trig = 1'b1; repeat (2) step(); ext_trig = 1'b0;
      repeat (4) step();
      check("R9 trigger starts", reg_rdata[6], 1);
      wait_flag(0, n);
      check("R9 trigger conv flag", reg_rdata[4], 1);
      check("R12 pulse count", starts, 14);

      // R10 free running
      wr(1, 8'h82);
      wr(0, 8'hF0);
      wait_flag(0, n);
      result_in = 10'h155;
      step(); step();
      check("R10 auto restart", reg_rdata[6], 1);
      @(negedge clk) irq_ack = 1'b1;
      @(posedge clk); #1 irq_ack = 1'b0;
      wait_flag(0, n);
      check("R10 second result", result_out, 10'h155);
      check("R12 chain pulses", starts, 16);
      wr(0, 8'h80);
      while (reg_rdata[6] === 1'b1) step();
      repeat (40) step();
      check("R10 chain stopped", reg_rdata[6], 0);

      done_run = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule